// File: doc/BRIEF.md
# Bunch-by-Bunch Co-Add Accumulator

This block sums the samples of each bunch slot of a storage ring over a programmed number of revolutions. One sample stream enters, with consecutive valid samples belonging to consecutive bunch slots. A revolution trigger marks the sample of the first bunch. Each slot keeps a running sum in a dual-port memory, which is updated by a read-modify-write pipeline.

The first pass of a co-add sequence loads the incoming sample into the slot. Each later pass adds the incoming sample to the stored sum. When a sequence of n passes has completed, the first pass of the next sequence reads each finished sum out into a FIFO as it loads the new sample. Accumulation therefore never pauses. A host drains the FIFO through a show-ahead read port. A sticky flag reports sums that were lost because the FIFO was full.

Top module: `co_add_accum`

## Requirements
- R1: After reset the FIFO is empty and `overflow` is 0. Samples that arrive before the first revolution trigger change nothing.
- R2: The sample that arrives with `rev_trig` goes to slot 0, and each later valid sample goes to the next slot. Cycles with `smp_valid` low do not advance the slot. A trigger without a valid sample makes the next valid sample slot 0. Samples beyond slot SLOTS-1 in a revolution are ignored.
- R3: On pass 1 of a sequence, the slot is loaded with the 12-bit signed sample sign-extended to 36 bits. Whatever the slot held before is replaced.
- R4: On passes 2 to n, the sign-extended sample is added to the stored 36-bit sum, modulo 2^36.
- R5: On pass 1 of every sequence after the first, the completed sum of each sampled slot is pushed into the FIFO in slot order. The sum appears at `fifo_dout` after the second rising edge that follows its sample.
- R6: Accesses to the same slot in consecutive cycles (revolutions of a single sample) always use the newest sum.
- R7: When a completed sum must be pushed while the FIFO is full, that sum is dropped and `overflow` is set. `overflow` then stays at 1 until reset.
- R8: A change of `pass_n` abandons the running sequence. The trigger that follows the change starts pass 1 with no push. A value of 0 for `pass_n` acts as 1.
- R9: The FIFO is show-ahead. `fifo_rd` with `fifo_empty` low removes the head word, and `fifo_rd` on an empty FIFO has no effect. `fifo_full` is 1 when the FIFO holds 2^FIFO_AW words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | SMP_W | Signed sample of the current bunch slot |
| rev_trig | input | 1 | Marks the first bunch of a revolution |
| pass_n | input | CNT_W | Revolutions per co-add sequence (0 acts as 1) |
| fifo_rd | input | 1 | Pop the head word of the FIFO |
| fifo_dout | output | SUM_W | Head word of the FIFO |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds its maximum number of words |
| overflow | output | 1 | Sticky: a completed sum was dropped |

## Verification
A wrong revolution count or slot pointer shows at the ports one sequence later. Either the number of pushed words is wrong, or the sums carry one pass too many or too few, or they come out of slot order. A lost forwarding path shows as a wrong sum only when a slot is touched in consecutive cycles, so single-sample revolutions are run on purpose. Because the bench compares the FIFO head, empty, full and overflow against its own model on every clock, a data or timing error is caught in the cycle in which the word first becomes visible, not later when it is read.

// File: rtl/cacc_pkg.sv
package cacc_pkg;
  // Operation carried by one accepted sample through the update pipeline.
  typedef enum logic {
    OP_LOAD = 1'b0,   // first pass: overwrite the slot
    OP_ACC  = 1'b1    // later passes: add into the slot
  } op_e;
endpackage

// File: rtl/cacc_ram.sv
module cacc_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Registered read, old data on a same-cycle collision.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/cacc_fifo.sv
module cacc_fifo #(
  parameter int DATA_W = 36,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] buf_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [AW:0]       cnt_q;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = buf_q[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) buf_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/cacc_seq.sv
module cacc_seq import cacc_pkg::*; #(
  parameter int SLOTS  = 75,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              rev_trig,
  input  logic [CNT_W-1:0]  pass_n,
  output logic              acc_en,
  output op_e               acc_op,
  output logic              acc_dump,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOTS);

  logic [CNT_W-1:0]  n_q, rev_q, n_eff, rev_nx;
  logic [SLOT_W-1:0] slot_q, slot_now;
  logic              dump_q, dump_now, n_chg, in_range;

  assign n_chg = (pass_n != n_q);
  assign n_eff = (n_q == '0) ? CNT_W'(1) : n_q;

  always_comb begin
    rev_nx   = rev_q;
    dump_now = dump_q;
    slot_now = slot_q;
    if (rev_trig) begin
      rev_nx   = (rev_q == '0 || rev_q == n_eff) ? CNT_W'(1) : rev_q + 1'b1;
      dump_now = (rev_q != '0) && (rev_q == n_eff);
      slot_now = '0;
    end
  end

  assign in_range = (slot_now < SLOT_END);
  assign acc_en   = !n_chg && smp_valid && (rev_nx != '0) && in_range;
  assign acc_op   = (rev_nx == CNT_W'(1)) ? OP_LOAD : OP_ACC;
  assign acc_dump = dump_now && (rev_nx == CNT_W'(1));
  assign acc_addr = ADDR_W'(slot_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q    <= '0;
      rev_q  <= '0;
      dump_q <= 1'b0;
      slot_q <= SLOT_END;
    end else begin
      n_q <= pass_n;
      if (n_chg) begin
        rev_q  <= '0;
        dump_q <= 1'b0;
        slot_q <= SLOT_END;
      end else begin
        rev_q  <= rev_nx;
        dump_q <= dump_now;
        if (smp_valid && in_range) slot_q <= slot_now + 1'b1;
        else if (rev_trig)         slot_q <= '0;
      end
    end
  end

  p_rev_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rev_q <= n_eff);
  p_nchg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    n_chg |=> (rev_q == '0));
  p_trig_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_trig && smp_valid && !n_chg) |=> (slot_q == SLOT_W'(1)));
endmodule

// File: rtl/co_add_accum.sv
module co_add_accum import cacc_pkg::*; #(
  parameter int SMP_W   = 12,
  parameter int SUM_W   = 36,
  parameter int SLOTS   = 75,
  parameter int ADDR_W  = 7,
  parameter int CNT_W   = 16,
  parameter int FIFO_AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             rev_trig,
  input  logic [CNT_W-1:0] pass_n,
  input  logic             fifo_rd,
  output logic [SUM_W-1:0] fifo_dout,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             overflow
);
  localparam int EXT_W = SUM_W - SMP_W;

  function automatic logic [SUM_W-1:0] widen(input logic [SMP_W-1:0] s);
    return {{EXT_W{s[SMP_W-1]}}, s};
  endfunction

  function automatic logic [SUM_W-1:0] fold(input logic [SUM_W-1:0] a,
                                            input logic [SUM_W-1:0] b);
    return a + b;
  endfunction

  // Stage 0: slot sequencing, memory read issue.
  logic              acc_en, acc_dump;
  op_e               acc_op;
  logic [ADDR_W-1:0] acc_addr;

  cacc_seq #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .rev_trig (rev_trig),
    .pass_n   (pass_n),
    .acc_en   (acc_en),
    .acc_op   (acc_op),
    .acc_dump (acc_dump),
    .acc_addr (acc_addr)
  );

  // Stage 1: combine, write back, push.
  logic              s1_v, s1_dump, s1_fwd;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [SUM_W-1:0]  s1_smp, s1_fwd_data, ram_q, old_val, new_val;
  logic              evt_push, evt_drop, evt_fwd;

  cacc_ram #(.ADDR_W(ADDR_W), .DATA_W(SUM_W)) u_ram (
    .clk    (clk),
    .wr_en  (s1_v),
    .wr_addr(s1_addr),
    .wr_data(new_val),
    .rd_en  (acc_en),
    .rd_addr(acc_addr),
    .rd_data(ram_q)
  );

  assign evt_fwd = acc_en && s1_v && (s1_addr == acc_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v        <= 1'b0;
      s1_dump     <= 1'b0;
      s1_fwd      <= 1'b0;
      s1_op       <= OP_LOAD;
      s1_addr     <= '0;
      s1_smp      <= '0;
      s1_fwd_data <= '0;
    end else begin
      s1_v        <= acc_en;
      s1_dump     <= acc_dump;
      s1_fwd      <= evt_fwd;
      s1_op       <= acc_op;
      s1_addr     <= acc_addr;
      s1_smp      <= widen(smp_data);
      s1_fwd_data <= new_val;
    end
  end

  assign old_val  = s1_fwd ? s1_fwd_data : ram_q;
  assign new_val  = (s1_op == OP_ACC) ? fold(old_val, s1_smp) : s1_smp;
  assign evt_push = s1_v && (s1_op == OP_LOAD) && s1_dump;
  assign evt_drop = evt_push && fifo_full;

  cacc_fifo #(.DATA_W(SUM_W), .AW(FIFO_AW)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (evt_push),
    .din  (old_val),
    .pop  (fifo_rd),
    .dout (fifo_dout),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (evt_drop) overflow <= 1'b1;
  end

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> overflow);
  p_fwd_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_fwd |-> ($past(s1_v) && ($past(s1_addr) == s1_addr)));
endmodule

// File: tb/sim_co_add_accum.sv
module sim_co_add_accum;
  localparam int SW = 12, UW = 36, NS = 75, AW = 7, CW = 16, FAW = 4;
  localparam int FD = 1 << FAW;

  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0, rev_trig = 1'b0, fifo_rd = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [CW-1:0] pass_n = '0;
  logic [UW-1:0] fifo_dout;
  logic fifo_empty, fifo_full, overflow;

  always #2 clk = ~clk;  // 250 MHz

  co_add_accum #(.SMP_W(SW), .SUM_W(UW), .SLOTS(NS), .ADDR_W(AW),
                 .CNT_W(CW), .FIFO_AW(FAW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rev_trig(rev_trig), .pass_n(pass_n), .fifo_rd(fifo_rd),
    .fifo_dout(fifo_dout), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .overflow(overflow));

  int tests = 0, fails = 0;
  longint MASK = (longint'(1) << UW) - 1;

  // Behavioural model state
  longint mem_m [128];
  longint expq [$];
  longint got [$];
  int  n_m = 0, rev_m = 0, slot_m = NS;
  bit  dump_m = 0, ovf_m = 0;
  bit  pv = 0, pload = 0, pdump = 0;
  int  paddr = 0;
  longint psmp = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int val(input int k, input int seed);
    if (k == 0) return -2048;
    if (k == 1) return 2047;
    return ((k * 37 + seed * 11) % 4096) - 2048;
  endfunction

  always @(posedge clk) begin
    bit full_b, dn, acc;
    int ne, rn, sn;
    longint old;
    if (!rst_n) begin
      n_m = 0; rev_m = 0; slot_m = NS; dump_m = 0; ovf_m = 0; pv = 0;
      expq.delete();
    end else begin
      full_b = (expq.size() == FD);
      if (fifo_rd && expq.size() > 0) got.push_back(expq.pop_front());
      if (pv) begin
        old = mem_m[paddr];
        if (pload && pdump) begin
          if (full_b) ovf_m = 1;
          else expq.push_back(old);
        end
        mem_m[paddr] = pload ? psmp : ((old + psmp) & MASK);
      end
      pv = 0;
      if (int'(pass_n) != n_m) begin
        n_m = int'(pass_n); rev_m = 0; dump_m = 0; slot_m = NS;
      end else begin
        ne = (n_m == 0) ? 1 : n_m;
        rn = rev_m; dn = dump_m; sn = slot_m;
        if (rev_trig) begin
          dn = (rev_m == ne);
          rn = (rev_m == 0 || rev_m == ne) ? 1 : rev_m + 1;
          sn = 0;
        end
        acc = smp_valid && (rn != 0) && (sn < NS);
        if (acc) begin
          pv = 1; pload = (rn == 1); pdump = dn && (rn == 1); paddr = sn;
          psmp = longint'($signed(smp_data)) & MASK;
        end
        if (smp_valid && sn < NS) slot_m = sn + 1;
        else if (rev_trig)        slot_m = 0;
        rev_m = rn; dump_m = dn;
      end
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 fifo_empty", longint'(fifo_empty), longint'(expq.size() == 0));
      chk("R9 fifo_full", longint'(fifo_full), longint'(expq.size() == FD));
      chk("R7 overflow", longint'(overflow), longint'(ovf_m));
      if (expq.size() > 0) chk("R5 fifo_dout", longint'(fifo_dout), expq[0]);
    end
  end

  task automatic smp(input bit trig, input int v);
    @(negedge clk);
    smp_valid = 1'b1; rev_trig = trig; smp_data = SW'(v);
  endtask

  task automatic idle(input int c);
    repeat (c) begin
      @(negedge clk);
      smp_valid = 1'b0; rev_trig = 1'b0;
    end
  endtask

  task automatic rev(input int nsmp, input int seed, input bit gaps);
    for (int k = 0; k < nsmp; k++) begin
      smp(k == 0, val(k, seed));
      if (gaps && (k % 5 == 2)) idle(1);
    end
    idle(1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    chk("R1 reset fifo_empty", longint'(fifo_empty), 1);
    chk("R1 reset overflow", longint'(overflow), 0);
    rst_n = 1'b1;
    fifo_rd = 1'b1;
    pass_n = CW'(3);
    idle(2);
    for (int k = 0; k < 10; k++) smp(0, 100 + k);  // R1: no trigger yet
    idle(4);
    chk("R1 pre-trigger samples ignored", longint'(fifo_empty), 1);

    // R2/R3/R4/R5: sequence of three passes, with gaps and an over-long revolution
    rev(NS, 1, 0);
    rev(NS, 2, 1);
    rev(NS + 5, 3, 0);
    rev(NS, 4, 0);
    idle(10);
    chk("R5 words per sequence", got.size(), NS);
    chk("R4 slot0 negative sum", got[0], longint'(-6144) & MASK);
    chk("R4 slot1 positive sum", got[1], 6141);
    chk("R2 slot2 order", got[2],
        (longint'(val(2,1) + val(2,2) + val(2,3))) & MASK);
    rev(NS, 5, 1);
    rev(NS, 6, 0);
    rev(NS, 7, 0);
    idle(10);
    chk("R5 second sequence count", got.size(), 2 * NS);
    chk("R3 load replaces old sum", got[NS + 1], 6141);

    // R8: changing the pass count abandons the sequence; 1 and 0 both act as 1
    pass_n = CW'(1);
    idle(2);
    rev(NS, 8, 0);
    idle(5);
    chk("R8 no push after change", got.size(), 2 * NS);
    rev(NS, 9, 0);
    idle(10);
    chk("R8 single-pass dump", got[2 * NS + 3], longint'(val(3, 8)) & MASK);
    pass_n = CW'(0);
    idle(2);
    rev(NS, 10, 0);
    rev(NS, 11, 0);
    idle(10);
    chk("R8 zero acts as one", got[got.size() - NS + 5], longint'(val(5, 10)) & MASK);

    // R6: single-sample revolutions hit slot 0 back to back
    pass_n = CW'(4);
    idle(2);
    smp(1, 5); smp(1, 6); smp(1, 7); smp(1, 8); smp(1, 1);
    idle(6);
    chk("R6 back-to-back sum", got[got.size() - 1], 26);

    // R7: host stalls, FIFO fills, excess sums dropped
    fifo_rd = 1'b0;
    pass_n = CW'(1);
    idle(2);
    base = got.size();
    rev(NS, 12, 0);
    rev(NS, 13, 0);
    idle(5);
    chk("R7 overflow set", longint'(overflow), 1);
    chk("R7 fifo_full", longint'(fifo_full), 1);
    fifo_rd = 1'b1;
    idle(FD + 10);
    chk("R7 kept words", got.size() - base, FD);
    chk("R7 last kept word", got[got.size() - 1], longint'(val(FD - 1, 12)) & MASK);
    idle(3);
    chk("R9 read on empty", longint'(fifo_empty), 1);
    chk("R7 overflow sticky", longint'(overflow), 1);
    finish_run();
  end
endmodule